// File: doc/BRIEF.md
# Cross-Trigger Routing Matrix

The block gathers event pulses from debug and performance sources on a trigger input vector. It folds them onto a few shared broadcast channels and drives a trigger output vector from those channels. A typical use is turning a counter-overflow event into a held interrupt line that software later clears. Software programs the routing through a 32-bit register bus. Each trigger input has a mask that picks the channels it feeds. Each trigger output has a mask that picks the channels it listens to. A global enable gates all routing. Software can also hold channels active, or fire them for a single clock, without any trigger input.

Every write passes through a two-state lock machine. Its states are LOCKED and OPEN. The transition *unlock* (LOCKED or OPEN to OPEN) fires when the key word 0xC5ACCE55 is written to the lock-access register. The transition *relock* (OPEN or LOCKED to LOCKED) fires when any other word is written there. While the machine is in LOCKED, every other write is dropped. Reset places the machine in LOCKED. Each trigger output is a sticky flag. It stays set until software acknowledges it or routing is disabled.

Top module: `xtrig_matrix`

## Requirements
- R1: After reset the lock status reads 1, the control register reads 0, all channel masks read 0, the held channel mask reads 0 and trig_out is 0.
- R2: Writing 0xC5ACCE55 to offset 0xFB0 opens the block and any other word there locks it. Bit 0 of offset 0xFB4 reads 1 when locked and 0 when open. Offset 0xFB0 reads 0.
- R3: While locked, writes to any offset other than 0xFB0 change no register and acknowledge no output.
- R4: Bit 0 of offset 0x000 is the global enable. While it is 0, chan_status and offset 0x13C read 0 and no output is set. From the clock after the enable falls, trig_out is 0.
- R5: Bit c of the mask at offset 0x020+4n connects trigger input n to channel c. An input whose mask is zero reaches no channel. Offset 0x138 shows, per channel, whether any connected input is high, without regard to the enable.
- R6: Bit c of the mask at offset 0x0A0+4n lets channel c set trigger output n. The output reads 1 from the clock edge that samples the active channel.
- R7: A set output stays 1 after its sources fall. Writing 1 to bit n of offset 0x010 clears output n at that write's edge, unless a source still sets it in the same cycle, in which case it stays 1. Offset 0x010 reads 0.
- R8: A write to offset 0x014 ORs its low channel bits into a held channel mask. A write to 0x018 clears the held bits where it has 1s. Held channels stay active while enabled. Offset 0x014 reads back the held mask, and 0x018 reads 0.
- R9: A write to offset 0x01C makes the written channels active for exactly the one clock after the write edge. It can latch outputs at the following edge. Offset 0x01C reads 0.
- R10: Offset 0x130 reads the raw trigger inputs, 0x134 the trigger outputs, and 0x13C the active channels, which equal chan_status.
- R11: Reads of offsets that map to no register return 0. Examples are 0x040, 0x0C0 and 0x200.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Byte offset of the access (bits 1:0 ignored) |
| bus_we | input | 1 | Write strobe, one write per clock it is high |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| trig_in | input | 8 | Trigger input levels |
| trig_out | output | 8 | Sticky trigger outputs |
| chan_status | output | 4 | Currently active channels |

## Verification
A corrupted input or output mask shows on trig_out at the very next clock edge after the input is driven, as a missing or extra output bit. A mask readback that disagrees with what was written shows on the same cycle's read. A lock machine in the wrong state shows one write later, as a control or mask value that did or did not change when read back. A broken sticky flag or acknowledge path shows one cycle after the input falls or the acknowledge is written. The sweep pairs every input with every channel against a fixed set of output masks, so each crosspoint of the matrix is driven once.

// File: rtl/xtrig_pkg.sv
package xtrig_pkg;
    localparam logic [31:0] UNLOCK_KEY = 32'hC5AC_CE55;

    // word offsets (byte offset >> 2)
    localparam logic [9:0] W_CTRL     = 10'h000;
    localparam logic [9:0] W_ACK      = 10'h004;
    localparam logic [9:0] W_APPSET   = 10'h005;
    localparam logic [9:0] W_APPCLR   = 10'h006;
    localparam logic [9:0] W_APPPULSE = 10'h007;
    localparam logic [9:0] W_IN0      = 10'h008;
    localparam logic [9:0] W_OUT0     = 10'h028;
    localparam logic [9:0] W_TIN      = 10'h04C;
    localparam logic [9:0] W_TOUT     = 10'h04D;
    localparam logic [9:0] W_CHIN     = 10'h04E;
    localparam logic [9:0] W_CHOUT    = 10'h04F;
    localparam logic [9:0] W_LOCKACC  = 10'h3EC;
    localparam logic [9:0] W_LOCKSTAT = 10'h3ED;

    typedef enum logic {
        LK_OPEN   = 1'b0,
        LK_LOCKED = 1'b1
    } lock_state_t;
endpackage

// File: rtl/xtrig_lock.sv
module xtrig_lock
    import xtrig_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [9:0]  wi,
    input  logic        we,
    input  logic [31:0] wdata,
    output logic        locked
);
    lock_state_t state_q, state_d;
    logic        hit;

    assign hit = we && (wi == W_LOCKACC);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LK_LOCKED: if (hit && wdata == UNLOCK_KEY) state_d = LK_OPEN;
            LK_OPEN:   if (hit && wdata != UNLOCK_KEY) state_d = LK_LOCKED;
            default:   state_d = LK_LOCKED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LK_LOCKED;
        else        state_q <= state_d;
    end

    always_comb begin
        locked = (state_q == LK_LOCKED);
    end

    assert_key_opens_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && wdata == UNLOCK_KEY) |=> !locked);
    assert_badkey_locks_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && wdata != UNLOCK_KEY) |=> locked);
endmodule

// File: rtl/xtrig_regs.sv
module xtrig_regs
    import xtrig_pkg::*;
#(
    parameter int N_TIN  = 8,
    parameter int N_TOUT = 8,
    parameter int N_CH   = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [9:0]                   wi,
    input  logic                         we,
    input  logic [31:0]                  wdata,
    input  logic                         locked,
    input  logic [N_TIN-1:0]             tin_raw,
    input  logic [N_TOUT-1:0]            tout,
    input  logic [N_CH-1:0]              chan_evt,
    input  logic [N_CH-1:0]              chan_act,
    output logic                         en,
    output logic [N_TIN-1:0][N_CH-1:0]   in_mask,
    output logic [N_TOUT-1:0][N_CH-1:0]  out_mask,
    output logic [N_CH-1:0]              app_held,
    output logic [N_CH-1:0]              app_pulse,
    output logic [N_TOUT-1:0]            ack,
    output logic [31:0]                  rdata
);
    logic wr_ok;
    logic unused_wd;

    assign wr_ok     = we && !locked;
    assign unused_wd = ^wdata;

    always_comb begin
        ack = '0;
        if (wr_ok && wi == W_ACK) ack = wdata[N_TOUT-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en        <= 1'b0;
            app_held  <= '0;
            app_pulse <= '0;
            in_mask   <= '0;
            out_mask  <= '0;
        end else begin
            app_pulse <= '0;
            if (wr_ok) begin
                if (wi == W_CTRL)     en        <= wdata[0];
                if (wi == W_APPSET)   app_held  <= app_held | wdata[N_CH-1:0];
                if (wi == W_APPCLR)   app_held  <= app_held & ~wdata[N_CH-1:0];
                if (wi == W_APPPULSE) app_pulse <= wdata[N_CH-1:0];
                for (int n = 0; n < N_TIN; n++)
                    if (wi == 10'(W_IN0 + 10'(n)))  in_mask[n]  <= wdata[N_CH-1:0];
                for (int n = 0; n < N_TOUT; n++)
                    if (wi == 10'(W_OUT0 + 10'(n))) out_mask[n] <= wdata[N_CH-1:0];
            end
        end
    end

    always_comb begin
        rdata = '0;
        unique case (wi)
            W_CTRL:     rdata[0]        = en;
            W_APPSET:   rdata[N_CH-1:0] = app_held;
            W_TIN:      rdata[N_TIN-1:0]  = tin_raw;
            W_TOUT:     rdata[N_TOUT-1:0] = tout;
            W_CHIN:     rdata[N_CH-1:0] = chan_evt;
            W_CHOUT:    rdata[N_CH-1:0] = chan_act;
            W_LOCKSTAT: rdata[0]        = locked;
            default:    ;
        endcase
        for (int n = 0; n < N_TIN; n++)
            if (wi == 10'(W_IN0 + 10'(n)))  rdata[N_CH-1:0] = in_mask[n];
        for (int n = 0; n < N_TOUT; n++)
            if (wi == 10'(W_OUT0 + 10'(n))) rdata[N_CH-1:0] = out_mask[n];
    end

    assert_locked_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && we && wi != W_LOCKACC) |=> ($stable(en) && $stable(in_mask) && $stable(out_mask)));
    assert_app_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ok && wi == W_APPCLR) |=> ((app_held & $past(wdata[N_CH-1:0])) == '0));
    assert_pulse_once_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_ok && wi == W_APPPULSE) |=> (app_pulse == '0));
endmodule

// File: rtl/xtrig_route.sv
module xtrig_route #(
    parameter int N_TIN  = 8,
    parameter int N_TOUT = 8,
    parameter int N_CH   = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         en,
    input  logic [N_TIN-1:0]             tin,
    input  logic [N_TIN-1:0][N_CH-1:0]   in_mask,
    input  logic [N_TOUT-1:0][N_CH-1:0]  out_mask,
    input  logic [N_CH-1:0]              app_held,
    input  logic [N_CH-1:0]              app_pulse,
    input  logic [N_TOUT-1:0]            ack,
    output logic [N_CH-1:0]              chan_evt,
    output logic [N_CH-1:0]              chan_act,
    output logic [N_TOUT-1:0]            tout
);
    logic [N_TOUT-1:0] set_req;

    always_comb begin
        chan_evt = '0;
        for (int n = 0; n < N_TIN; n++)
            chan_evt = chan_evt | ({N_CH{tin[n]}} & in_mask[n]);
        chan_act = en ? (chan_evt | app_held | app_pulse) : '0;
    end

    for (genvar n = 0; n < N_TOUT; n++) begin : g_out
        assign set_req[n] = |(chan_act & out_mask[n]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   tout <= '0;
        else if (!en) tout <= '0;
        else          tout <= (tout & ~ack) | set_req;
    end

    assert_disable_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (tout == '0));
    assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> ((($past(tout) & ~$past(ack)) & ~tout) == '0));
endmodule

// File: rtl/xtrig_matrix.sv
module xtrig_matrix
    import xtrig_pkg::*;
#(
    parameter int N_TIN  = 8,
    parameter int N_TOUT = 8,
    parameter int N_CH   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [11:0]       bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [N_TIN-1:0]  trig_in,
    output logic [N_TOUT-1:0] trig_out,
    output logic [N_CH-1:0]   chan_status
);
    logic [9:0]                  wi;
    logic                        unused_lsb;
    logic                        locked;
    logic                        en;
    logic [N_TIN-1:0][N_CH-1:0]  in_mask;
    logic [N_TOUT-1:0][N_CH-1:0] out_mask;
    logic [N_CH-1:0]             app_held, app_pulse, chan_evt, chan_act;
    logic [N_TOUT-1:0]           ack, tout;

    assign wi          = bus_addr[11:2];
    assign unused_lsb  = ^bus_addr[1:0];
    assign trig_out    = tout;
    assign chan_status = chan_act;

    xtrig_lock u_lock (
        .clk(clk), .rst_n(rst_n), .wi(wi), .we(bus_we),
        .wdata(bus_wdata), .locked(locked)
    );

    xtrig_regs #(.N_TIN(N_TIN), .N_TOUT(N_TOUT), .N_CH(N_CH)) u_regs (
        .clk(clk), .rst_n(rst_n), .wi(wi), .we(bus_we), .wdata(bus_wdata),
        .locked(locked), .tin_raw(trig_in), .tout(tout), .chan_evt(chan_evt),
        .chan_act(chan_act), .en(en), .in_mask(in_mask), .out_mask(out_mask),
        .app_held(app_held), .app_pulse(app_pulse), .ack(ack), .rdata(bus_rdata)
    );

    xtrig_route #(.N_TIN(N_TIN), .N_TOUT(N_TOUT), .N_CH(N_CH)) u_route (
        .clk(clk), .rst_n(rst_n), .en(en), .tin(trig_in), .in_mask(in_mask),
        .out_mask(out_mask), .app_held(app_held), .app_pulse(app_pulse),
        .ack(ack), .chan_evt(chan_evt), .chan_act(chan_act), .tout(tout)
    );
endmodule

// File: tb/xtrig_matrix_tb.sv
module xtrig_matrix_tb;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] KEY = 32'hC5AC_CE55;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  trig_in = '0;
    logic [7:0]  trig_out;
    logic [3:0]  chan_status;

    int nchk = 0;
    int nfail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xtrig_matrix u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .trig_in(trig_in),
        .trig_out(trig_out), .chan_status(chan_status)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd_chk(input logic [11:0] a, input logic [31:0] exp, input string tag);
        bus_addr = a;
        #1;
        chk(bus_rdata, exp, tag);
    endtask

    function automatic logic [3:0] omask(input int n);
        return 4'((n + 1) % 16);
    endfunction

    function automatic logic [7:0] exp_out(input logic [3:0] ch);
        logic [7:0] r = '0;
        for (int n = 0; n < 8; n++) r[n] = |(omask(n) & ch);
        return r;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        rd_chk(12'hFB4, 32'h1, "R1 lock status");
        rd_chk(12'h000, 32'h0, "R1 control");
        rd_chk(12'h014, 32'h0, "R1 held mask");
        for (int n = 0; n < 8; n++) begin
            rd_chk(12'(32'h020 + 4*n), 32'h0, "R1 input mask");
            rd_chk(12'(32'h0A0 + 4*n), 32'h0, "R1 output mask");
        end
        chk({24'h0, trig_out}, 32'h0, "R1 trig_out");

        // R3 writes while locked are dropped
        wr(12'h000, 32'h1);
        wr(12'h020, 32'hF);
        rd_chk(12'h000, 32'h0, "R3 control locked");
        rd_chk(12'h020, 32'h0, "R3 mask locked");

        // R2 lock key
        wr(12'hFB0, 32'h1234_5678);
        rd_chk(12'hFB4, 32'h1, "R2 bad key stays locked");
        wr(12'hFB0, KEY);
        rd_chk(12'hFB4, 32'h0, "R2 key opens");
        rd_chk(12'hFB0, 32'h0, "R2 access reads zero");

        wr(12'h000, 32'h1);
        rd_chk(12'h000, 32'h1, "R4 enable readback");
        for (int n = 0; n < 8; n++) wr(12'(32'h0A0 + 4*n), 32'(omask(n)));
        for (int n = 0; n < 8; n++) rd_chk(12'(32'h0A0 + 4*n), 32'(omask(n)), "R6 output mask readback");

        // R11 unmapped
        rd_chk(12'h040, 32'h0, "R11 0x040");
        rd_chk(12'h0C0, 32'h0, "R11 0x0C0");
        rd_chk(12'h200, 32'h0, "R11 0x200");
        rd_chk(12'h010, 32'h0, "R7 ack reads zero");
        rd_chk(12'h01C, 32'h0, "R9 pulse reads zero");

        // R5/R6/R7 sweep of every input against every channel
        for (int i = 0; i < 8; i++) begin
            for (int c = 0; c < 4; c++) begin
                wr(12'(32'h020 + 4*i), 32'(1 << c));
                rd_chk(12'(32'h020 + 4*i), 32'(1 << c), "R5 input mask readback");
                trig_in = ~(8'(1 << i));
                @(negedge clk);
                chk({24'h0, trig_out}, 32'h0, "R5 unmapped inputs ignored");
                chk({28'h0, chan_status}, 32'h0, "R5 unmapped channel idle");
                trig_in = 8'(1 << i);
                @(negedge clk);
                chk({24'h0, trig_out}, {24'h0, exp_out(4'(1 << c))}, "R6 routed output");
                chk({28'h0, chan_status}, 32'(1 << c), "R5 channel active");
                rd_chk(12'h138, 32'(1 << c), "R10 channel input status");
                rd_chk(12'h130, 32'(1 << i), "R10 raw input status");
                trig_in = '0;
                @(negedge clk);
                chk({24'h0, trig_out}, {24'h0, exp_out(4'(1 << c))}, "R7 sticky");
                rd_chk(12'h134, {24'h0, exp_out(4'(1 << c))}, "R10 output status");
                wr(12'h010, 32'hFF);
                chk({24'h0, trig_out}, 32'h0, "R7 ack clears");
                wr(12'(32'h020 + 4*i), 32'h0);
            end
        end

        // R8 held channels, R7 set wins over ack
        wr(12'h014, 32'h5);
        rd_chk(12'h014, 32'h5, "R8 held readback");
        chk({28'h0, chan_status}, 32'h5, "R8 held active");
        rd_chk(12'h13C, 32'h5, "R10 channel output status");
        @(negedge clk);
        chk({24'h0, trig_out}, {24'h0, exp_out(4'h5)}, "R8 held sets outputs");
        wr(12'h010, 32'hFF);
        chk({24'h0, trig_out}, {24'h0, exp_out(4'h5)}, "R7 set wins over ack");
        wr(12'h018, 32'h4);
        rd_chk(12'h014, 32'h1, "R8 clear bit");
        rd_chk(12'h018, 32'h0, "R8 clear reads zero");
        wr(12'h010, 32'hFF);
        chk({24'h0, trig_out}, {24'h0, exp_out(4'h1)}, "R7 ack partial");
        // R3 locked ack ignored
        wr(12'h018, 32'hF);
        wr(12'h014, 32'h2);
        @(negedge clk);
        wr(12'h018, 32'h2);
        wr(12'hFB0, 32'h0);
        rd_chk(12'hFB4, 32'h1, "R2 relock");
        wr(12'h010, 32'hFF);
        chk({24'h0, trig_out}, {24'h0, exp_out(4'h3)}, "R3 ack ignored locked");
        wr(12'h000, 32'h0);
        rd_chk(12'h000, 32'h1, "R3 control kept");
        wr(12'hFB0, KEY);
        wr(12'h010, 32'hFF);
        chk({24'h0, trig_out}, 32'h0, "R7 ack after reopen");

        // R9 pulse for one clock
        wr(12'h01C, 32'h8);
        chk({28'h0, chan_status}, 32'h8, "R9 pulse active");
        @(negedge clk);
        chk({28'h0, chan_status}, 32'h0, "R9 pulse over");
        chk({24'h0, trig_out}, {24'h0, exp_out(4'h8)}, "R9 pulse latched");

        // R4 disable
        wr(12'h014, 32'h2);
        @(negedge clk);
        wr(12'h000, 32'h0);
        chk({28'h0, chan_status}, 32'h0, "R4 channels off");
        @(negedge clk);
        chk({24'h0, trig_out}, 32'h0, "R4 outputs cleared");
        wr(12'h018, 32'hF);
        wr(12'h020, 32'hF);
        trig_in = 8'h01;
        @(negedge clk);
        @(negedge clk);
        chk({24'h0, trig_out}, 32'h0, "R4 no latch when off");
        rd_chk(12'h138, 32'hF, "R5 channel input ignores enable");
        rd_chk(12'h13C, 32'h0, "R4 channel output off");
        trig_in = '0;
        wr(12'h000, 32'h1);
        @(negedge clk);
        chk({24'h0, trig_out}, 32'h0, "R7 no stale event after enable");

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule